// File: doc/BRIEF.md
# Interrupt Flag and Request Logic

This block collects three interrupt events of a timekeeping core: a periodic tick, an alarm hit and the end of a time update. Each event arrives as a one-cycle set pulse and latches a sticky flag. A flag is set whether or not its source is enabled, so software can poll for events with every interrupt masked.

Software reads a flag byte. It holds the three event flags and a summary bit that is high while any flag is pending together with its enable. Reading the byte returns the flags as they stand in that cycle and clears all of them together. An event that lands in the same cycle as the clearing read is kept for the next read. The request output models an open-drain line: it either pulls low or releases. It pulls low exactly while the summary bit is high.

Top module: `irq_flag_unit`

## Requirements
- R1: After reset all flags are 0, `flagData` reads 8'h00 and `reqPullLow` is 0.
- R2: A set pulse sets its flag, visible on `flagData` from the cycle after the pulse, whatever its enable. Bit 6 is the tick flag, bit 5 the alarm flag and bit 4 the update-done flag.
- R3: Bits 3 to 0 of `flagData` always read 0.
- R4: Bit 7 of `flagData` is 1 exactly when some flag is set and its own enable is 1. It follows the enables in the same cycle.
- R5: `reqPullLow` (1 = drive the line low, 0 = release) equals bit 7 of `flagData`. It is never 1 unless an enabled flag is pending.
- R6: While `flagRd` is high, `flagData` shows the flags held before the read. From the next cycle all flags are 0, unless R7 applies.
- R7: A set pulse in the same cycle as `flagRd` leaves its flag set after the read.
- R8: With no read, a set flag stays set.
- R9: After a clearing read with no set pulse in that cycle, `reqPullLow` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickHit | input | 1 | Periodic tick set pulse |
| alarmHit | input | 1 | Alarm match set pulse |
| updDone | input | 1 | Update-done set pulse |
| tickEn | input | 1 | Tick interrupt enable |
| alarmEn | input | 1 | Alarm interrupt enable |
| updEn | input | 1 | Update-done interrupt enable |
| flagRd | input | 1 | Flag byte read strobe (clears flags) |
| flagData | output | 8 | Flag byte: summary, tick, alarm, update-done, zeros |
| reqPullLow | output | 1 | 1 pulls the interrupt line low, 0 releases it |

## Verification
A set pulse and the clearing read can fall in the same cycle. The bench provokes this twice: once with a single source into empty flags, and once with all three sources together while other flags are already pending. In both cases it judges the outcome by the flag byte and the request line one cycle later. It also checks that the byte returned during the read cycle still shows the flags held before the read.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int SRC_N     = 3;   // tick, alarm, update-done
  localparam int FLAG_W    = 8;
  localparam int FIELD_LSB = 4;   // update-done at bit 4, alarm 5, tick 6
  localparam int SUM_POS   = FLAG_W - 1;

  typedef struct packed {
    logic [SRC_N-1:0] setMask;   // [2]=tick [1]=alarm [0]=update-done
    logic             clearAll;
  } flag_strobe_t;
endpackage

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
(
  input  logic         tickHit,
  input  logic         alarmHit,
  input  logic         updDone,
  input  logic         flagRd,
  output flag_strobe_t strobe
);
  always_comb begin
    strobe.setMask  = {tickHit, alarmHit, updDone};
    strobe.clearAll = flagRd;
  end
endmodule

// File: rtl/irq_flag_store.sv
module irq_flag_store
  import irq_flag_pkg::*;
#(
  parameter int NSRC  = SRC_N,
  parameter int WIDTH = FLAG_W,
  parameter int LSB   = FIELD_LSB
) (
  input  logic             clk,
  input  logic             rstN,
  input  flag_strobe_t     strobe,
  input  logic [NSRC-1:0]  enMask,
  output logic [WIDTH-1:0] flagData,
  output logic             reqPullLow
);
  localparam int TOP = WIDTH - 1;

  logic [NSRC-1:0] flags;
  logic [NSRC-1:0] flagsNext;
  logic            summary;

  genvar i;
  generate
    for (i = 0; i < NSRC; i++) begin : g_src
      // set pulse wins over the clearing read
      assign flagsNext[i] = strobe.setMask[i] | (flags[i] & ~strobe.clearAll);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) flags <= '0;
    else       flags <= flagsNext;
  end

  assign summary = |(flags & enMask);

  always_comb begin
    flagData = '0;
    flagData[TOP] = summary;
    flagData[LSB +: NSRC] = flags;
  end

  assign reqPullLow = summary;
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
  import irq_flag_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickHit,
  input  logic        alarmHit,
  input  logic        updDone,
  input  logic        tickEn,
  input  logic        alarmEn,
  input  logic        updEn,
  input  logic        flagRd,
  output logic [7:0]  flagData,
  output logic        reqPullLow
);
  flag_strobe_t strobe;

  irq_flag_ctrl u_ctrl (
    .tickHit (tickHit),
    .alarmHit(alarmHit),
    .updDone (updDone),
    .flagRd  (flagRd),
    .strobe  (strobe)
  );

  irq_flag_store #(
    .NSRC (SRC_N),
    .WIDTH(FLAG_W),
    .LSB  (FIELD_LSB)
  ) u_store (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .enMask    ({tickEn, alarmEn, updEn}),
    .flagData  (flagData),
    .reqPullLow(reqPullLow)
  );
endmodule

// File: rtl/irq_flag_checker.sv
module irq_flag_checker (
  input logic       clk,
  input logic       rstN,
  input logic       tickHit,
  input logic       alarmHit,
  input logic       updDone,
  input logic       tickEn,
  input logic       alarmEn,
  input logic       updEn,
  input logic       flagRd,
  input logic [7:0] flagData,
  input logic       reqPullLow
);
  logic anySet;
  assign anySet = tickHit | alarmHit | updDone;

  AST_ALARM_SETS: assert property (@(posedge clk) disable iff (!rstN)
    alarmHit |=> flagData[5]); // R2
  AST_REQ_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    reqPullLow |-> ((tickEn && flagData[6]) || (alarmEn && flagData[5]) || (updEn && flagData[4]))); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (flagRd && !anySet) |=> (flagData[6:4] == 3'b000)); // R6
  AST_SET_BEATS_READ: assert property (@(posedge clk) disable iff (!rstN)
    (flagRd && tickHit) |=> flagData[6]); // R7
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!flagRd && flagData[5]) |=> flagData[5]); // R8
  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (flagRd && !anySet) |=> !reqPullLow); // R9
endmodule

bind irq_flag_unit irq_flag_checker chk (
  .clk(clk), .rstN(rstN), .tickHit(tickHit), .alarmHit(alarmHit),
  .updDone(updDone), .tickEn(tickEn), .alarmEn(alarmEn), .updEn(updEn),
  .flagRd(flagRd), .flagData(flagData), .reqPullLow(reqPullLow)
);

// File: tb/irq_flag_unit_test.sv
`timescale 1ns/1ps
module irq_flag_unit_test;
  logic clk = 0;
  logic rstN = 0;
  logic tickHit = 0, alarmHit = 0, updDone = 0;
  logic tickEn = 0, alarmEn = 0, updEn = 0;
  logic flagRd = 0;
  logic [7:0] flagData;
  logic reqPullLow;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  irq_flag_unit uut (
    .clk(clk), .rstN(rstN), .tickHit(tickHit), .alarmHit(alarmHit),
    .updDone(updDone), .tickEn(tickEn), .alarmEn(alarmEn), .updEn(updEn),
    .flagRd(flagRd), .flagData(flagData), .reqPullLow(reqPullLow)
  );

  // vector: set{tick,alarm,upd}[15:13] en{tick,alarm,upd}[12:10] rd[9] expFlags[8:1] expReq[0]
  localparam int NV = 12;
  localparam logic [15:0] VEC [NV] = '{
    {3'b010, 3'b000, 1'b0, 8'h20, 1'b0},  // R2 alarm set while masked
    {3'b000, 3'b010, 1'b0, 8'hA0, 1'b1},  // R4 R5 enable raises summary
    {3'b100, 3'b010, 1'b0, 8'hE0, 1'b1},  // R2 tick joins
    {3'b000, 3'b000, 1'b1, 8'h00, 1'b0},  // R6 read clears
    {3'b001, 3'b001, 1'b0, 8'h90, 1'b1},  // R2 update-done
    {3'b000, 3'b001, 1'b1, 8'h00, 1'b0},  // R9 release after read
    {3'b100, 3'b100, 1'b1, 8'hC0, 1'b1},  // R7 set with read, empty flags
    {3'b000, 3'b000, 1'b0, 8'h40, 1'b0},  // R8 hold, masked
    {3'b000, 3'b100, 1'b0, 8'hC0, 1'b1},  // R8 R4 still held
    {3'b111, 3'b000, 1'b1, 8'h70, 1'b0},  // R7 all set with read
    {3'b000, 3'b111, 1'b0, 8'hF0, 1'b1},  // R4 all enabled
    {3'b000, 3'b111, 1'b1, 8'h00, 1'b0}   // R6 R9 final clear
  };

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  initial begin
    logic [7:0] prevFlags;
    repeat (3) @(negedge clk);
    #1;
    check8("R1 reset flagData", flagData, 8'h00);
    check8("R1 reset reqPullLow", {7'd0, reqPullLow}, 8'h00);
    rstN = 1;
    prevFlags = 8'h00;
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      {tickHit, alarmHit, updDone} = VEC[v][15:13];
      {tickEn, alarmEn, updEn}     = VEC[v][12:10];
      flagRd                       = VEC[v][9];
      #1;
      if (flagRd)
        check8($sformatf("R6 read-cycle value vec %0d", v), {5'd0, flagData[6:4]}, {5'd0, prevFlags[6:4]});
      @(negedge clk);
      {tickHit, alarmHit, updDone} = 3'b000;
      flagRd = 0;
      #1;
      check8($sformatf("R2 R4 R6 R7 R8 flags vec %0d", v), flagData, VEC[v][8:1]);
      check8($sformatf("R5 R9 request vec %0d", v), {7'd0, reqPullLow}, {7'd0, VEC[v][0]});
      check8($sformatf("R3 low bits vec %0d", v), {4'd0, flagData[3:0]}, 8'h00);
      prevFlags = VEC[v][8:1];
    end
    // R4: summary tracks enable in the same cycle
    @(negedge clk);
    updDone = 1;
    @(negedge clk);
    updDone = 0; updEn = 0; tickEn = 0; alarmEn = 0;
    #1;
    check8("R4 masked flag", flagData, 8'h10);
    updEn = 1;
    #1;
    check8("R4 enable same cycle", flagData, 8'h90);
    check8("R5 request same cycle", {7'd0, reqPullLow}, 8'h01);
    // R1: reset clears pending flags
    rstN = 0;
    @(negedge clk);
    #1;
    check8("R1 reset clears", flagData, 8'h00);
    check8("R1 reset releases", {7'd0, reqPullLow}, 8'h00);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (10000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule